// File: doc/BRIEF.md
# Identification Byte Readout Sequencer

This block generates the serial data output of a SPI flash slave while it answers an identification read. The opcode decoder and the address shifter sit outside this block. When they have accepted the command and its address, they pulse `id_start` and present the low address bit on `id_addr_lsb`. The SCK falling-edge detector pulses `sck_fall_stb` once per falling edge. The sequencer then shifts out three identity bytes, most significant bit first, with one new bit on each falling-edge strobe.

The three bytes are the primary manufacturer code, the device code and the continuation manufacturer code. The low address bit selects which of the first two is sent first. The continuation code is always third. While chip select stays low the series wraps around and starts again from its first byte. Raising chip select at any moment ends the transfer, turns the output driver off and clears every counter.

Top module: `idr_seq_top`

## Requirements
- R1: After reset `so_oe` is 0 and `so_data` is 0.
- R2: Before an `id_start` pulse has been accepted, `sck_fall_stb` pulses leave `so_oe` at 0. The output stays off while the opcode and address are shifted in.
- R3: After an accepted `id_start`, `so_oe` stays 0 until the first `sck_fall_stb`. On the clock edge that samples that strobe, `so_oe` becomes 1 and `so_data` carries bit 7 of the first byte. Each further strobe moves to the next lower bit on that same edge.
- R4: With `id_addr_lsb` = 0 the byte order is primary manufacturer code (`MFR_PRIMARY`, default 9Dh), then device code (`DEVICE_CODE`, default 22h), then continuation code (`MFR_CONT`, default 7Fh).
- R5: With `id_addr_lsb` = 1 the byte order is device code, then primary manufacturer code, then continuation code.
- R6: The strobe that follows bit 0 of the third byte sends bit 7 of the first byte again. The series repeats without limit while `cs_n` stays low.
- R7: `cs_n` high on a clock edge drives `so_oe` and `so_data` to 0 on that edge and clears the armed state and the bit and byte positions. A later `id_start` begins again from bit 7 of the first byte.
- R8: While `so_oe` is 1, `so_data` does not change on clock edges where there is no strobe, no start pulse and no rise of `cs_n`.
- R9: An `id_start` pulse that arrives while `cs_n` is high is ignored: later `sck_fall_stb` pulses leave `so_oe` at 0.
- R10: `cs_n` high takes priority over `id_start`, and `id_start` takes priority over `sck_fall_stb`. A start pulse during a transfer re-arms the sequencer: `so_oe` goes to 0 and the next strobe sends bit 7 of the first byte in the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| id_start | input | 1 | One-cycle pulse: the ID command and its address have been received |
| id_addr_lsb | input | 1 | Low address bit of the command, sampled with `id_start` |
| sck_fall_stb | input | 1 | One-cycle pulse per SCK falling edge |
| so_data | output | 1 | Serial output bit |
| so_oe | output | 1 | Output driver enable; 0 means the pin is tri-stated |

## Verification
The main function is driven by a table of transfers. Each entry pairs an address bit with a strobe count of 8, 24, 30, 49 or 60 bits. The 8-bit entries show that the two orders open differently. The 24-bit entries show where the second byte falls. The longer entries cross one or two wrap points and end part way through a byte. Directed tests then cover strobes before any start, a start pulse while chip select is high, a chip-select abort in mid-byte followed by a fresh start, and a re-arm with the opposite address bit during a transfer. A stretch of idle cycles between strobes shows that the output bit holds steady.

// File: rtl/idr_pkg.sv
package idr_pkg;

    // Which byte opens the identification series.
    typedef enum logic {
        ORD_MFR_FIRST = 1'b0,
        ORD_DEV_FIRST = 1'b1
    } id_order_e;

    // Slot numbers within one pass of the series.
    localparam int unsigned SLOT_COUNT = 3;
    localparam int unsigned SLOT_W     = 2;

endpackage

// File: rtl/idr_byte_select.sv
module idr_byte_select
    import idr_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter logic [BYTE_W-1:0] MFR_PRIMARY = 8'h9D,
    parameter logic [BYTE_W-1:0] MFR_CONT    = 8'h7F,
    parameter logic [BYTE_W-1:0] DEVICE_CODE = 8'h22
) (
    input  id_order_e         order,
    input  logic [SLOT_W-1:0] slot,
    output logic [BYTE_W-1:0] id_byte
);

    // The first two slots swap with the order; the continuation code is always last.
    always_comb begin
        unique case (slot)
            2'd0:    id_byte = (order == ORD_DEV_FIRST) ? DEVICE_CODE : MFR_PRIMARY;
            2'd1:    id_byte = (order == ORD_DEV_FIRST) ? MFR_PRIMARY : DEVICE_CODE;
            default: id_byte = MFR_CONT;
        endcase
    end

endmodule

// File: rtl/idr_position.sv
module idr_position
    import idr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned BIT_W = $clog2(BYTE_W)
) (
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bit_idx_nxt,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              wrap
);

    localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_COUNT - 1);

    // Step one bit down; past bit 0, go to the MSB of the next slot and wrap after the last one.
    always_comb begin
        wrap        = 1'b0;
        bit_idx_nxt = bit_idx - 1'b1;
        slot_nxt    = slot;
        if (bit_idx == '0) begin
            bit_idx_nxt = BIT_TOP;
            if (slot == SLOT_LAST) begin
                slot_nxt = '0;
                wrap     = 1'b1;
            end else begin
                slot_nxt = slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/idr_seq_top.sv
module idr_seq_top
    import idr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter logic [BYTE_W-1:0] MFR_PRIMARY = 8'h9D,
    parameter logic [BYTE_W-1:0] MFR_CONT    = 8'h7F,
    parameter logic [BYTE_W-1:0] DEVICE_CODE = 8'h22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic id_start,
    input  logic id_addr_lsb,
    input  logic sck_fall_stb,
    output logic so_data,
    output logic so_oe
);

    localparam int unsigned BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0]  BIT_TOP   = BIT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_COUNT - 1);

    typedef struct packed {
        logic              armed;
        logic              active;
        id_order_e         order;
        logic [BIT_W-1:0]  bit_idx;
        logic [SLOT_W-1:0] slot;
        logic              dout;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [BYTE_W-1:0] cur_byte;
    logic [BIT_W-1:0]  bit_nxt;
    logic [SLOT_W-1:0] slot_nxt;
    logic              pass_wrap;

    idr_byte_select #(
        .BYTE_W      (BYTE_W),
        .MFR_PRIMARY (MFR_PRIMARY),
        .MFR_CONT    (MFR_CONT),
        .DEVICE_CODE (DEVICE_CODE)
    ) u_sel (
        .order   (st_q.order),
        .slot    (st_q.slot),
        .id_byte (cur_byte)
    );

    idr_position #(
        .BYTE_W (BYTE_W)
    ) u_pos (
        .bit_idx     (st_q.bit_idx),
        .slot        (st_q.slot),
        .bit_idx_nxt (bit_nxt),
        .slot_nxt    (slot_nxt),
        .wrap        (pass_wrap)
    );

    // Next-state logic. The stored position always points at the bit to be sent on the next strobe.
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = '0;
        end else if (id_start) begin
            st_d.armed   = 1'b1;
            st_d.active  = 1'b0;
            st_d.order   = id_addr_lsb ? ORD_DEV_FIRST : ORD_MFR_FIRST;
            st_d.bit_idx = BIT_TOP;
            st_d.slot    = '0;
            st_d.dout    = 1'b0;
        end else if (sck_fall_stb && (st_q.armed || st_q.active)) begin
            st_d.armed   = 1'b0;
            st_d.active  = 1'b1;
            st_d.dout    = cur_byte[st_q.bit_idx];
            st_d.bit_idx = bit_nxt;
            st_d.slot    = slot_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign so_data = st_q.dout;
    assign so_oe   = st_q.active;

    // R7: chip select high clears the driver and the armed state.
    a_r7_cs_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!so_oe && !so_data && !st_q.armed));

    // R3: the driver only turns on at a falling-edge strobe.
    a_r3_enable_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> $past(sck_fall_stb));

    // R8: the output bit holds between strobes.
    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !sck_fall_stb && !cs_n && !id_start) |=> $stable(so_data));

    // R6: after bit 0 of the last slot, the position returns to the MSB of slot 0.
    a_r6_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && sck_fall_stb && !cs_n && !id_start &&
         st_q.slot == SLOT_LAST && st_q.bit_idx == '0)
        |=> (st_q.slot == '0 && st_q.bit_idx == BIT_TOP));

    // R4/R5: the first bit sent after arming is the MSB of the byte the order selects.
    a_r4_r5_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && sck_fall_stb && !cs_n && !id_start)
        |=> (so_data == ((st_q.order == ORD_DEV_FIRST) ? DEVICE_CODE[BYTE_W-1]
                                                       : MFR_PRIMARY[BYTE_W-1])));

    // R10: a start pulse with chip select low re-arms and turns the driver off.
    a_r10_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (id_start && !cs_n) |=> (st_q.armed && !so_oe));

    // R2/R9: the driver never turns on without a prior accepted start.
    a_r2_no_drive_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !st_q.active) |=> !so_oe);

endmodule

// File: tb/sim_idr_seq_top.sv
module sim_idr_seq_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic id_start = 1'b0;
    logic id_addr_lsb = 1'b0;
    logic sck_fall_stb = 1'b0;
    logic so_data, so_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [7:0] MFR1 = 8'h9D;
    localparam logic [7:0] MFR2 = 8'h7F;
    localparam logic [7:0] DEV  = 8'h22;

    // Each entry: {address bit, number of strobes}.
    localparam int NVEC = 6;
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b0, 8'd8}, {1'b1, 8'd8}, {1'b0, 8'd24},
        {1'b1, 8'd30}, {1'b0, 8'd60}, {1'b1, 8'd49}
    };

    always #4 clk = ~clk;

    idr_seq_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .id_start     (id_start),
        .id_addr_lsb  (id_addr_lsb),
        .sck_fall_stb (sck_fall_stb),
        .so_data      (so_data),
        .so_oe        (so_oe)
    );

    // Expected bit k (0-based) of the series for a given address bit.
    function automatic logic exp_bit(input logic lsb, input int k);
        logic [7:0] b;
        int slot = (k / 8) % 3;
        if (slot == 0)      b = lsb ? DEV : MFR1;
        else if (slot == 1) b = lsb ? MFR1 : DEV;
        else                b = MFR2;
        return b[7 - (k % 8)];
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // Signals are driven at negedge; the posedge between samples them.
    task automatic strobe();
        @(negedge clk) sck_fall_stb = 1'b1;
        @(negedge clk) sck_fall_stb = 1'b0;
    endtask

    task automatic start_cmd(input logic lsb);
        @(negedge clk) begin id_start = 1'b1; id_addr_lsb = lsb; end
        @(negedge clk) id_start = 1'b0;
    endtask

    task automatic deselect();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: got hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 oe", so_oe, 1'b0);
        check("R1 data", so_data, 1'b0);
        rst_n = 1'b1;

        // R9: start while deselected is ignored.
        start_cmd(1'b0);
        @(negedge clk) cs_n = 1'b0;
        strobe();
        check("R9 start with cs high ignored", so_oe, 1'b0);

        // R2: strobes during opcode/address phase keep output off.
        deselect();
        repeat (4) begin
            strobe();
            check("R2 off before start", so_oe, 1'b0);
        end

        // Table of transfers: R3, R4, R5, R6.
        for (int v = 0; v < NVEC; v++) begin
            logic lsb = VEC[v][8];
            int n = int'(VEC[v][7:0]);
            deselect();
            start_cmd(lsb);
            check("R3 off after start", so_oe, 1'b0);
            for (int k = 0; k < n; k++) begin
                strobe();
                check("R3 oe on", so_oe, 1'b1);
                check(k >= 24 ? "R6 wrap bit" : (lsb ? "R5 order bit" : "R4 order bit"),
                      so_data, exp_bit(lsb, k));
            end
        end

        // R8: output holds across idle cycles.
        deselect();
        start_cmd(1'b0);
        strobe();
        repeat (5) begin
            @(negedge clk);
            check("R8 hold", so_data, exp_bit(1'b0, 0));
        end

        // R7: abort mid-byte, then restart from the first byte.
        repeat (4) strobe();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check("R7 oe off", so_oe, 1'b0);
        check("R7 data 0", so_data, 1'b0);
        cs_n = 1'b0;
        strobe();
        check("R7 no drive after abort", so_oe, 1'b0);
        start_cmd(1'b0);
        for (int k = 0; k < 8; k++) begin
            strobe();
            check("R7 restart bit", so_data, exp_bit(1'b0, k));
        end

        // R10: re-arm mid-transfer with the opposite order.
        start_cmd(1'b1);
        check("R10 rearm oe off", so_oe, 1'b0);
        for (int k = 0; k < 10; k++) begin
            strobe();
            check("R10 rearm bit", so_data, exp_bit(1'b1, k));
        end

        // R10: start and strobe together: start wins.
        @(negedge clk) begin id_start = 1'b1; id_addr_lsb = 1'b0; sck_fall_stb = 1'b1; end
        @(negedge clk) begin id_start = 1'b0; sck_fall_stb = 1'b0; end
        check("R10 start over strobe", so_oe, 1'b0);
        strobe();
        check("R10 first bit after start", so_data, exp_bit(1'b0, 0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule